// File: doc/BRIEF.md
# Multi-cell voltage protection controller

This block guards a series lithium-ion stack of three or four cells. A front end outside the block digitizes every cell voltage into a millivolt code and presents all codes in parallel. The block evaluates them each time a periodic sample strobe arrives, which is nominally every 8.5 ms. Each active cell is compared against an overvoltage window and an undervoltage window. Each window has separate entry and exit levels, so the response has hysteresis. A condition takes effect only after two consecutive strobes agree, which gives about 17 ms of filtering at the nominal rate.

The block drives two enables: `chg_on` lets the external charge switch conduct, and `dchg_on` lets the discharge switch conduct. A confirmed overvoltage removes charging. A confirmed undervoltage removes discharging and puts the block into a low-power sleep. In sleep, strobes are ignored until a charger-present input wakes it. A cell-count select input chooses four cells when low and three cells when high. The board-level pull that makes an open input mean four cells belongs to the integration. A charge-permit input must be high for charging to happen at all.

Top module: `cell_guard`

## Requirements
- R1: `three_cell_sel` low selects four cells and high selects three. In three-cell mode the code of cell 3, `cell_codes[4*CODE_W-1:3*CODE_W]`, takes no part in any comparison. Cell i always sits at `cell_codes[i*CODE_W +: CODE_W]`.
- R2: Overvoltage is entered after two consecutive strobes on which any active cell code is at least OV_SET (default 4200). `chg_on` goes low in the cycle after the second strobe.
- R3: Overvoltage is left only after two consecutive strobes on which every active cell code is at most OV_CLR (default 4000). A code between the two levels keeps the present state.
- R4: Undervoltage is entered after two consecutive strobes on which any active cell code is at most UV_SET (default 2300). `dchg_on` goes low and `asleep` goes high in the same cycle.
- R5: Undervoltage is left only after two consecutive strobes on which every active cell code is at least UV_CLR (default 2600). `dchg_on` then returns high.
- R6: A strobe that does not meet the pending condition clears the confirmation count, so one isolated qualifying sample never changes an output.
- R7: `chg_on` is high only while `chg_allow` is high and no overvoltage is in force.
- R8: While `asleep` is high, strobes are ignored and neither `chg_on` nor `dchg_on` changes because of cell codes.
- R9: `charger_wake` high while asleep clears `asleep` at the next clock edge, and evaluation resumes. `charger_wake` while awake has no effect.
- R10: After reset the block is in the normal state: `dchg_on` is high, `asleep` is low, `chg_on` follows `chg_allow`, and no strobe has yet been counted.
- R11: The overvoltage and undervoltage conditions are judged independently, and both can take effect on the same strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| sample_tick | input | 1 | One-cycle strobe: cell codes are valid this cycle |
| cell_codes | input | 4*CODE_W | Cell millivolt codes, cell i at bits [i*CODE_W +: CODE_W] |
| three_cell_sel | input | 1 | 0: four cells, 1: three cells |
| chg_allow | input | 1 | Charging permitted when high |
| charger_wake | input | 1 | Charger present, wakes the block from sleep |
| chg_on | output | 1 | Charge switch enable |
| dchg_on | output | 1 | Discharge switch enable |
| asleep | output | 1 | Sleep state indicator |

## Verification
An overvoltage confirmation and an undervoltage confirmation can complete on the same strobe when one cell sits above the high entry level while another sits below the low one. The bench holds cell 0 at 4300 and cell 1 at 2000 for two strobes. It then expects `chg_on` and `dchg_on` to fall, and `asleep` to rise, all in the one cycle after the second strobe. Sleep entry and a wake request can also meet at one edge. There the rule is that only a wake seen while already asleep counts, so the bench checks that the block still ends up asleep. Boundary sweeps then walk each cell through the codes on either side of all four levels, in both cell-count modes, and compare the outputs against an arithmetic model after every strobe.

// File: rtl/cellguard_pkg.sv
// Package: shared types for the cell guard.
// Assumes: nothing beyond IEEE 1800-2017.
package cellguard_pkg;

    // Per-cell comparison result against both hysteresis windows.
    typedef struct packed {
        logic ov_hit;  // code at or above overvoltage entry level
        logic ov_ok;   // code at or below overvoltage exit level
        logic uv_hit;  // code at or below undervoltage entry level
        logic uv_ok;   // code at or above undervoltage exit level
    } cell_flags_t;

endpackage

// File: rtl/cell_window.sv
// Module: cell_window
// Compares one cell code against the entry and exit levels of both windows.
// Assumes: unsigned millivolt codes; an inactive cell must never block an
// exit or cause an entry, so it reports "ok" on both windows and no hit.
module cell_window #(
    parameter int CODE_W = 13,
    parameter int OV_SET = 4200,
    parameter int OV_CLR = 4000,
    parameter int UV_SET = 2300,
    parameter int UV_CLR = 2600
) (
    input  logic [CODE_W-1:0]         code,
    input  logic                      active,
    output cellguard_pkg::cell_flags_t flags
);

    // Purpose: threshold compares, masked by the cell's active bit.
    always_comb begin
        flags.ov_hit = active & (code >= CODE_W'(OV_SET));
        flags.ov_ok  = ~active | (code <= CODE_W'(OV_CLR));
        flags.uv_hit = active & (code <= CODE_W'(UV_SET));
        flags.uv_ok  = ~active | (code >= CODE_W'(UV_CLR));
    end

endmodule

// File: rtl/hyst_qualifier.sv
// Module: hyst_qualifier
// Holds one protection state. Entry needs CONFIRM consecutive steps with the
// set condition. Exit needs CONFIRM consecutive steps with the clear condition.
// A step that fails the pending condition clears the count.
// Assumes: step is a single-cycle strobe; set and clear conditions are
// stable while step is high.
module hyst_qualifier #(
    parameter int CONFIRM = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic step,
    input  logic set_cond,
    input  logic clr_cond,
    output logic state
);

    localparam int CNT_W = (CONFIRM > 1) ? $clog2(CONFIRM + 1) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(CONFIRM - 1);

    logic [CNT_W-1:0] cnt_q;
    logic             state_q;
    logic             cand;

    // Purpose: pick the condition that would move the state away from its present value.
    always_comb cand = state_q ? clr_cond : set_cond;

    // Purpose: count agreeing steps and flip the state on the last one.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q   <= '0;
            state_q <= 1'b0;
        end else if (step) begin
            if (cand) begin
                if (cnt_q == LAST) begin
                    state_q <= ~state_q;
                    cnt_q   <= '0;
                end else begin
                    cnt_q <= cnt_q + 1'b1;
                end
            end else begin
                cnt_q <= '0;
            end
        end
    end

    assign state = state_q;

    AST_CHANGE_CONFIRMED: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != $past(state_q)) |-> $past(step && cand && (cnt_q == LAST))); // R6

endmodule

// File: rtl/cell_guard.sv
// Module: cell_guard (top)
// Applies overvoltage and undervoltage hysteresis to a three- or four-cell
// stack, drives the charge and discharge enables, and sleeps after
// undervoltage until a charger is detected.
// Assumes: all cell codes are valid in the sample_tick cycle; the open-input
// default of three_cell_sel (four cells) is provided by a board pull-down.
module cell_guard #(
    parameter int N_CELLS = 4,
    parameter int CODE_W  = 13,
    parameter int OV_SET  = 4200,
    parameter int OV_CLR  = 4000,
    parameter int UV_SET  = 2300,
    parameter int UV_CLR  = 2600,
    parameter int CONFIRM = 2
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      sample_tick,
    input  logic [N_CELLS*CODE_W-1:0] cell_codes,
    input  logic                      three_cell_sel,
    input  logic                      chg_allow,
    input  logic                      charger_wake,
    output logic                      chg_on,
    output logic                      dchg_on,
    output logic                      asleep
);

    localparam int DROP_IDX = N_CELLS - 1;

    cellguard_pkg::cell_flags_t flags [N_CELLS];

    logic any_ov, all_ov_ok, any_uv, all_uv_ok;
    logic ov_state, uv_state;
    logic woken_q;
    logic step;

    // One window comparator per cell; the top cell drops out in three-cell mode.
    for (genvar gi = 0; gi < N_CELLS; gi++) begin : g_cell
        cell_window #(
            .CODE_W (CODE_W),
            .OV_SET (OV_SET),
            .OV_CLR (OV_CLR),
            .UV_SET (UV_SET),
            .UV_CLR (UV_CLR)
        ) u_win (
            .code   (cell_codes[gi*CODE_W +: CODE_W]),
            .active (!(three_cell_sel && (gi == DROP_IDX))),
            .flags  (flags[gi])
        );
    end

    // Purpose: fold per-cell results into stack-wide any/all conditions.
    always_comb begin
        any_ov    = 1'b0;
        all_ov_ok = 1'b1;
        any_uv    = 1'b0;
        all_uv_ok = 1'b1;
        for (int i = 0; i < N_CELLS; i++) begin
            any_ov    = any_ov    | flags[i].ov_hit;
            all_ov_ok = all_ov_ok & flags[i].ov_ok;
            any_uv    = any_uv    | flags[i].uv_hit;
            all_uv_ok = all_uv_ok & flags[i].uv_ok;
        end
    end

    // Purpose: strobes only count while awake.
    always_comb step = sample_tick & ~asleep;

    hyst_qualifier #(.CONFIRM(CONFIRM)) u_ovq (
        .clk      (clk),
        .rst_n    (rst_n),
        .step     (step),
        .set_cond (any_ov),
        .clr_cond (all_ov_ok),
        .state    (ov_state)
    );

    hyst_qualifier #(.CONFIRM(CONFIRM)) u_uvq (
        .clk      (clk),
        .rst_n    (rst_n),
        .step     (step),
        .set_cond (any_uv),
        .clr_cond (all_uv_ok),
        .state    (uv_state)
    );

    // Purpose: remember a charger wake for the rest of the undervoltage episode.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            woken_q <= 1'b0;
        end else if (!uv_state) begin
            woken_q <= 1'b0;
        end else if (charger_wake) begin
            woken_q <= 1'b1;
        end
    end

    // Purpose: output enables and the sleep indicator.
    always_comb begin
        asleep  = uv_state & ~woken_q;
        dchg_on = ~uv_state;
        chg_on  = chg_allow & ~ov_state;
    end

    AST_SLEEP_DCHG_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        asleep |-> !dchg_on); // R4

    AST_SLEEP_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (asleep && $past(asleep)) |-> ($stable(ov_state) && $stable(uv_state))); // R8

    AST_WAKE_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(asleep) |-> $past(charger_wake)); // R9

    AST_DCHG_NEEDS_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(dchg_on) |-> $past(sample_tick)); // R4

endmodule

// File: tb/test_cell_guard.sv
module test_cell_guard;

    localparam int CW = 13;
    localparam int NOM = 3700;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sample_tick = 1'b0;
    logic three_cell_sel = 1'b0;
    logic chg_allow = 1'b1;
    logic charger_wake = 1'b0;
    logic [CW-1:0] cells [4];
    logic [4*CW-1:0] cell_codes;
    logic chg_on, dchg_on, asleep;

    int n_checks = 0;
    int n_errors = 0;
    bit finished = 1'b0;

    // Bench model of the requirements.
    int m_ov = 0, m_uv = 0, m_sl = 0, m_ovc = 0, m_uvc = 0;

    assign cell_codes = {cells[3], cells[2], cells[1], cells[0]};

    always #2 clk = ~clk;

    cell_guard i_cell_guard (
        .clk            (clk),
        .rst_n          (rst_n),
        .sample_tick    (sample_tick),
        .cell_codes     (cell_codes),
        .three_cell_sel (three_cell_sel),
        .chg_allow      (chg_allow),
        .charger_wake   (charger_wake),
        .chg_on         (chg_on),
        .dchg_on        (dchg_on),
        .asleep         (asleep)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic check_all(input string tag);
        chk({tag, " chg_on"}, chg_on, (chg_allow && !m_ov) ? 1 : 0);
        chk({tag, " dchg_on"}, dchg_on, m_uv ? 0 : 1);
        chk({tag, " asleep"}, asleep, m_sl);
    endtask

    // Model of one strobe, per R1..R6 and R11.
    task automatic model_tick();
        int any_ov = 0, all_ovok = 1, any_uv = 0, all_uvok = 1;
        int cand;
        if (m_sl) return;
        for (int i = 0; i < 4; i++) begin
            if (!(three_cell_sel && i == 3)) begin
                if (cells[i] >= 4200) any_ov = 1;
                if (cells[i] > 4000) all_ovok = 0;
                if (cells[i] <= 2300) any_uv = 1;
                if (cells[i] < 2600) all_uvok = 0;
            end
        end
        cand = m_ov ? all_ovok : any_ov;
        if (cand) begin
            if (m_ovc == 1) begin m_ov = !m_ov; m_ovc = 0; end
            else m_ovc++;
        end else m_ovc = 0;
        cand = m_uv ? all_uvok : any_uv;
        if (cand) begin
            if (m_uvc == 1) begin
                m_uv = !m_uv; m_uvc = 0;
                if (m_uv) m_sl = 1;
            end else m_uvc++;
        end else m_uvc = 0;
    endtask

    task automatic do_tick(input string tag);
        @(negedge clk);
        sample_tick = 1'b1;
        @(negedge clk);
        sample_tick = 1'b0;
        model_tick();
        check_all(tag);
    endtask

    task automatic do_wake(input string tag);
        @(negedge clk);
        charger_wake = 1'b1;
        @(negedge clk);
        charger_wake = 1'b0;
        if (m_sl) m_sl = 0;
        check_all(tag);
    endtask

    task automatic set_nominal();
        for (int i = 0; i < 4; i++) cells[i] = CW'(NOM);
    endtask

    task automatic recover();
        set_nominal();
        if (m_sl) do_wake("R9 recover wake");
        for (int k = 0; k < 3; k++) do_tick("R3/R5 recover");
    endtask

    initial begin
        int vals [8] = '{4199, 4200, 4001, 4000, 2301, 2300, 2599, 2600};
        set_nominal();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check_all("R10 reset state");

        // R7: charge permit gates charging
        chg_allow = 1'b0;
        #1;
        chk("R7 chg_allow low", chg_on, 0);
        chg_allow = 1'b1;
        #1;
        chk("R7 chg_allow high", chg_on, 1);

        // R6: isolated glitch then R2 confirmation
        cells[0] = CW'(4300);
        do_tick("R6 first sample");
        set_nominal();
        do_tick("R6 disagreeing sample");
        cells[0] = CW'(4300);
        do_tick("R6 restart count");
        chk("R6 glitch no change", chg_on, 1);
        do_tick("R2 second sample");
        chk("R2 charge off", chg_on, 0);
        // R3: between levels holds, at exit level leaves after two
        cells[0] = CW'(4100);
        do_tick("R3 hold in band");
        do_tick("R3 hold in band 2");
        chk("R3 still off", chg_on, 0);
        cells[0] = CW'(4000);
        do_tick("R3 exit 1");
        do_tick("R3 exit 2");
        chk("R3 charge back", chg_on, 1);
        // R7 with overvoltage and permit both influencing
        chg_allow = 1'b0;
        do_tick("R7 permit low");
        chg_allow = 1'b1;

        // R9: wake while awake has no effect
        do_wake("R9 wake while awake");

        // R11: both conditions on the same strobe
        set_nominal();
        cells[0] = CW'(4300);
        cells[1] = CW'(2000);
        do_tick("R11 first");
        do_tick("R11 second");
        chk("R11 chg off same cycle", chg_on, 0);
        chk("R11 dchg off same cycle", dchg_on, 0);
        chk("R4 asleep same cycle", asleep, 1);
        // R8: strobes ignored while asleep
        set_nominal();
        do_tick("R8 frozen 1");
        do_tick("R8 frozen 2");
        chk("R8 charge still off", chg_on, 0);
        // R9: wake and R5/R3 recovery
        do_wake("R9 wake");
        chk("R9 awake", asleep, 0);
        do_tick("R5 exit 1");
        do_tick("R5 exit 2");
        chk("R5 dchg back", dchg_on, 1);
        chk("R3 chg back", chg_on, 1);

        // R4 sleep entry while a wake is present at the same edge
        cells[2] = CW'(2300);
        do_tick("R4 uv 1");
        @(negedge clk);
        sample_tick = 1'b1;
        charger_wake = 1'b1;
        @(negedge clk);
        sample_tick = 1'b0;
        charger_wake = 1'b0;
        model_tick();
        check_all("R9 wake on entry edge ignored");
        recover();

        // R1..R5 boundary sweeps in both cell-count modes
        for (int mode = 0; mode < 2; mode++) begin
            three_cell_sel = mode[0];
            for (int c = 0; c < 4; c++) begin
                for (int v = 0; v < 8; v++) begin
                    set_nominal();
                    cells[c] = CW'(vals[v]);
                    do_tick("R1/R2/R4 sweep 1");
                    do_tick("R1/R2/R4 sweep 2");
                    recover();
                end
            end
        end

        // R3/R5 exit boundaries: just outside the exit level keeps the state
        three_cell_sel = 1'b0;
        set_nominal();
        cells[1] = CW'(4250);
        do_tick("R2 set a");
        do_tick("R2 set b");
        cells[1] = CW'(4001);
        do_tick("R3 above exit a");
        do_tick("R3 above exit b");
        chk("R3 4001 holds", chg_on, 0);
        recover();
        cells[3] = CW'(2200);
        do_tick("R4 set a");
        do_tick("R4 set b");
        do_wake("R9 wake b");
        cells[3] = CW'(2599);
        do_tick("R5 below exit a");
        do_tick("R5 below exit b");
        chk("R5 2599 holds", dchg_on, 0);
        recover();

        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: actual 0 expected 1 (run did not complete)");
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    end

endmodule